// File: doc/BRIEF.md
# CD Sector Decoder Register Emulation

This block presents the register face of a CD-ROM sector decoder to a CPU, without a disc behind it. The CPU loads a requested timecode (minutes, seconds, frames, all BCD) through a position load port. The block keeps that value in its header registers, so a read-back matches the request. A host agent delivers whole 2048-byte sectors elsewhere and pulses `sector_done` when each one has arrived. The block then drives an active-low decoder interrupt, which the CPU clears by reading status register 3.

The status registers return fixed values that mean no errors, CRC good and decoder status valid. A read-only transfer pointer always holds 0x0004, which skips the four sector header bytes. The CPU writes a transfer byte count (normally 0x7FF) and a transfer start address (normally zero); both are exported for the DMA engine that follows. When that engine reports a finished copy on `copy_done`, the block advances the header timecode by one frame under CD timecode rules and emits a one-cycle `msf_inc` pulse.

The CPU port is a single-cycle strobe. Read data is combinational from the selected register, and the read side effect on status register 3 takes place at the clock edge where the strobe is sampled.

Top module: `cdsec_regs`

## Requirements
- R1: After reset `irq_n` is 1, `msf_inc` is 0, the header reads 0x00/0x00/0x00, the transfer count and address are zero and the interrupt enable (register 0xD bit 0) is 0.
- R2: A cycle with `pos_load` high copies `pos_min`, `pos_sec` and `pos_frm` into the header, which reads back at addresses 0x0 (minutes), 0x1 (seconds) and 0x2 (frames) from the next cycle.
- R3: The status registers return fixed values: 0x3 (status 0) reads 0x80, where bit 7 is CRC good and bits 6..0 are zero-error flags; 0x4 (status 1) reads 0x00; 0x5 (status 2) reads 0x00; 0x6 (status 3) reads 0x00, where bit 7 low means the decoder status is valid.
- R4: The transfer pointer reads 0x0004: 0x7 holds the low byte 0x04 and 0x8 holds the high byte 0x00. CPU writes to it, and to the header and status addresses, have no effect.
- R5: The 12-bit byte count is written at 0x9 (low byte) and 0xA (bits 3..0 of the data go to count bits 11..8; the upper nibble reads 0). The 16-bit transfer address is written at 0xB (low) and 0xC (high). Both read back and appear on `xfer_count` and `xfer_addr` from the cycle after the write.
- R6: With the enable set, a `sector_done` cycle drives `irq_n` low from the next cycle, and it stays low while nothing clears it.
- R7: A CPU read of address 0x6 clears a pending interrupt, so `irq_n` is high from the next cycle. A later `sector_done` raises it again.
- R8: Writing 0 to the enable bit releases `irq_n` at once and discards the pending interrupt. `sector_done` cycles seen while the enable is 0 are not recorded.
- R9: Each `copy_done` cycle produces exactly one `msf_inc` high cycle, in the following cycle, and advances the header by one frame.
- R10: The frame advance is BCD. Frames step from 0x74 to 0x00 and carry into seconds. Seconds step from 0x59 to 0x00 and carry into minutes. Minutes step from 0x99 to 0x00. A low digit of 9 carries into the high digit (0x09 becomes 0x10).
- R11: When `pos_load` and `copy_done` fall in the same cycle, the loaded value wins and the `msf_inc` pulse is still emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_sel | input | 1 | CPU register access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the addressed register |
| pos_load | input | 1 | Load requested timecode into header |
| pos_min | input | 8 | Requested minutes, BCD |
| pos_sec | input | 8 | Requested seconds, BCD |
| pos_frm | input | 8 | Requested frames, BCD |
| sector_done | input | 1 | Host finished delivering a sector |
| copy_done | input | 1 | DMA finished copying a 2048-byte sector |
| irq_n | output | 1 | Decoder interrupt, active low |
| msf_inc | output | 1 | One-cycle timecode advance pulse |
| xfer_count | output | 12 | Programmed transfer byte count |
| xfer_addr | output | 16 | Programmed transfer start address |

## Verification
On every cycle the assertions check the interrupt protocol: `irq_n` is never low while the enable is clear, a sector arrival with the enable set pulls it low, and a status 3 read releases it. They also check that `msf_inc` follows `copy_done` by exactly one cycle, that the frame digit wraps from 74, and that status 0 and the pointer read their fixed values. Some behaviour only the bench scenarios can show. These are the full BCD carry chains into seconds and minutes, the priority of a load over a same-cycle advance, the loss of sectors that arrive while disabled, and the masking of read-only and partly written registers.

// File: rtl/cdsec_pkg.sv
package cdsec_pkg;

  typedef enum logic [3:0] {
    A_MIN = 4'h0,
    A_SEC = 4'h1,
    A_FRM = 4'h2,
    A_ST0 = 4'h3,
    A_ST1 = 4'h4,
    A_ST2 = 4'h5,
    A_ST3 = 4'h6,
    A_PTL = 4'h7,
    A_PTH = 4'h8,
    A_CNL = 4'h9,
    A_CNH = 4'hA,
    A_DAL = 4'hB,
    A_DAH = 4'hC,
    A_IEN = 4'hD
  } reg_addr_e;

  localparam logic [7:0]  ST0_VAL = 8'h80;  // CRC good, no error flags
  localparam logic [7:0]  ST1_VAL = 8'h00;
  localparam logic [7:0]  ST2_VAL = 8'h00;
  localparam logic [7:0]  ST3_VAL = 8'h00;  // bit 7 low: status valid
  localparam logic [15:0] PTR_VAL = 16'h0004;

  localparam logic [7:0] FRM_LAST = 8'h74;
  localparam logic [7:0] SEC_LAST = 8'h59;
  localparam logic [7:0] MIN_LAST = 8'h99;

  function automatic logic bcd_at_last(input logic [7:0] v, input logic [7:0] last);
    return v == last;
  endfunction

  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] last);
    logic [7:0] r;
    if (v == last)           r = 8'h00;
    else if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
    else                     r = v + 8'h01;
    return r;
  endfunction

endpackage

// File: rtl/cdsec_msf.sv
module cdsec_msf
  import cdsec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_frm,
  input  logic       adv,
  output logic [7:0] min_q,
  output logic [7:0] sec_q,
  output logic [7:0] frm_q
);

  logic [7:0] min_d, sec_d, frm_d;
  logic       frm_wrap, sec_wrap;

  always_comb begin
    frm_wrap = bcd_at_last(frm_q, FRM_LAST);
    sec_wrap = bcd_at_last(sec_q, SEC_LAST);
    min_d    = min_q;
    sec_d    = sec_q;
    frm_d    = frm_q;
    if (load) begin
      min_d = ld_min;
      sec_d = ld_sec;
      frm_d = ld_frm;
    end else if (adv) begin
      frm_d = bcd_next(frm_q, FRM_LAST);
      if (frm_wrap) sec_d = bcd_next(sec_q, SEC_LAST);
      if (frm_wrap && sec_wrap) min_d = bcd_next(min_q, MIN_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= 8'h00;
      sec_q <= 8'h00;
      frm_q <= 8'h00;
    end else if (load || adv) begin
      min_q <= min_d;
      sec_q <= sec_d;
      frm_q <= frm_d;
    end
  end

endmodule

// File: rtl/cdsec_irq.sv
module cdsec_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sector_done,
  input  logic ack,
  output logic irq_n
);

  logic pend_q, pend_d;

  always_comb begin
    pend_d = en & (sector_done | (pend_q & ~ack));
    irq_n  = ~(pend_q & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/cdsec_cfg.sv
module cdsec_cfg
  import cdsec_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int DADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [DADDR_W-1:0] dadr_q,
  output logic               ien_q
);

  localparam int CNT_HI_W = CNT_W - 8;
  localparam int DA_HI_W  = DADDR_W - 8;

  logic [CNT_W-1:0]   cnt_d;
  logic [DADDR_W-1:0] dadr_d;
  logic               ien_d;

  always_comb begin
    cnt_d  = cnt_q;
    dadr_d = dadr_q;
    ien_d  = ien_q;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_CNL:   cnt_d[7:0]          = wr_data;
        A_CNH:   cnt_d[CNT_W-1:8]    = wr_data[CNT_HI_W-1:0];
        A_DAL:   dadr_d[7:0]         = wr_data;
        A_DAH:   dadr_d[DADDR_W-1:8] = wr_data[DA_HI_W-1:0];
        A_IEN:   ien_d               = wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dadr_q <= '0;
      ien_q  <= 1'b0;
    end else if (wr_en) begin
      cnt_q  <= cnt_d;
      dadr_q <= dadr_d;
      ien_q  <= ien_d;
    end
  end

endmodule

// File: rtl/cdsec_regs.sv
module cdsec_regs
  import cdsec_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int DADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel,
  input  logic               cpu_wr,
  input  logic [3:0]         cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  input  logic               pos_load,
  input  logic [7:0]         pos_min,
  input  logic [7:0]         pos_sec,
  input  logic [7:0]         pos_frm,
  input  logic               sector_done,
  input  logic               copy_done,
  output logic               irq_n,
  output logic               msf_inc,
  output logic [CNT_W-1:0]   xfer_count,
  output logic [DADDR_W-1:0] xfer_addr
);

  logic [1:0] rst_sync;
  logic       rst_s_n;
  logic       wr_en, st3_rd, irq_en, inc_q;
  logic [7:0] hdr_min, hdr_sec, hdr_frm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  always_comb begin
    wr_en  = cpu_sel & cpu_wr;
    st3_rd = cpu_sel & ~cpu_wr & (cpu_addr == 4'(A_ST3));
  end

  cdsec_msf u_msf (
    .clk(clk), .rst_n(rst_s_n), .load(pos_load),
    .ld_min(pos_min), .ld_sec(pos_sec), .ld_frm(pos_frm),
    .adv(copy_done), .min_q(hdr_min), .sec_q(hdr_sec), .frm_q(hdr_frm)
  );

  cdsec_irq u_irq (
    .clk(clk), .rst_n(rst_s_n), .en(irq_en),
    .sector_done(sector_done), .ack(st3_rd), .irq_n(irq_n)
  );

  cdsec_cfg #(.CNT_W(CNT_W), .DADDR_W(DADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_addr(cpu_addr),
    .wr_data(cpu_wdata), .cnt_q(xfer_count), .dadr_q(xfer_addr), .ien_q(irq_en)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) inc_q <= 1'b0;
    else          inc_q <= copy_done;
  end
  assign msf_inc = inc_q;

  always_comb begin
    case (reg_addr_e'(cpu_addr))
      A_MIN:   cpu_rdata = hdr_min;
      A_SEC:   cpu_rdata = hdr_sec;
      A_FRM:   cpu_rdata = hdr_frm;
      A_ST0:   cpu_rdata = ST0_VAL;
      A_ST1:   cpu_rdata = ST1_VAL;
      A_ST2:   cpu_rdata = ST2_VAL;
      A_ST3:   cpu_rdata = ST3_VAL;
      A_PTL:   cpu_rdata = PTR_VAL[7:0];
      A_PTH:   cpu_rdata = PTR_VAL[15:8];
      A_CNL:   cpu_rdata = xfer_count[7:0];
      A_CNH:   cpu_rdata = 8'(xfer_count[CNT_W-1:8]);
      A_DAL:   cpu_rdata = xfer_addr[7:0];
      A_DAH:   cpu_rdata = 8'(xfer_addr[DADDR_W-1:8]);
      A_IEN:   cpu_rdata = {7'b0, irq_en};
      default: cpu_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/cdsec_regs_chk.sv
module cdsec_regs_chk (
  input logic       clk,
  input logic       rst_s_n,
  input logic       cpu_sel,
  input logic       cpu_wr,
  input logic [3:0] cpu_addr,
  input logic [7:0] cpu_rdata,
  input logic       pos_load,
  input logic       sector_done,
  input logic       copy_done,
  input logic       irq_n,
  input logic       msf_inc,
  input logic       irq_en,
  input logic [7:0] hdr_frm
);

  logic ien_wr, st3_rd;
  assign ien_wr = cpu_sel & cpu_wr & (cpu_addr == 4'hD);
  assign st3_rd = cpu_sel & ~cpu_wr & (cpu_addr == 4'h6);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_s_n)
    !irq_n |-> irq_en);

  a_r6_sector_raises_irq: assert property (@(posedge clk) disable iff (!rst_s_n)
    sector_done && irq_en && !ien_wr |=> !irq_n);

  a_r7_stat3_read_clears: assert property (@(posedge clk) disable iff (!rst_s_n)
    st3_rd && !sector_done |=> irq_n);

  a_r9_inc_follows_copy: assert property (@(posedge clk) disable iff (!rst_s_n)
    copy_done |=> msf_inc);

  a_r9_inc_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    !copy_done |=> !msf_inc);

  a_r10_frame_wrap: assert property (@(posedge clk) disable iff (!rst_s_n)
    copy_done && !pos_load && hdr_frm == 8'h74 |=> hdr_frm == 8'h00);

  a_r3_stat0_value: assert property (@(posedge clk) disable iff (!rst_s_n)
    cpu_sel && !cpu_wr && cpu_addr == 4'h3 |-> cpu_rdata == 8'h80);

  a_r4_pointer_low: assert property (@(posedge clk) disable iff (!rst_s_n)
    cpu_sel && !cpu_wr && cpu_addr == 4'h7 |-> cpu_rdata == 8'h04);

endmodule

bind cdsec_regs cdsec_regs_chk u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .pos_load(pos_load),
  .sector_done(sector_done), .copy_done(copy_done), .irq_n(irq_n),
  .msf_inc(msf_inc), .irq_en(irq_en), .hdr_frm(hdr_frm)
);

// File: tb/cdsec_regs_bench.sv
`timescale 1ns/1ps
module cdsec_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [3:0]  cpu_addr = 4'h0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        pos_load = 1'b0;
  logic [7:0]  pos_min = 8'h00, pos_sec = 8'h00, pos_frm = 8'h00;
  logic        sector_done = 1'b0, copy_done = 1'b0;
  logic        irq_n, msf_inc;
  logic [11:0] xfer_count;
  logic [15:0] xfer_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  string      exp_tag[$];
  logic [7:0] exp_val[$];

  always #5 clk = ~clk;

  cdsec_regs u_cdsec_regs (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pos_load(pos_load), .pos_min(pos_min), .pos_sec(pos_sec), .pos_frm(pos_frm),
    .sector_done(sector_done), .copy_done(copy_done), .irq_n(irq_n),
    .msf_inc(msf_inc), .xfer_count(xfer_count), .xfer_addr(xfer_addr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    #3;
    if (cpu_sel && !cpu_wr) begin
      if (exp_val.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard unexpected read actual=%h expected=none", cpu_rdata);
      end else begin
        check(exp_tag.pop_front(), {8'h00, cpu_rdata}, {8'h00, exp_val.pop_front()});
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_tag.push_back(tag);
    exp_val.push_back(e);
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
    #1;
  endtask

  task automatic load_pos(input logic [7:0] m, input logic [7:0] s, input logic [7:0] f, input bit with_copy);
    @(negedge clk);
    pos_load = 1'b1; pos_min = m; pos_sec = s; pos_frm = f; copy_done = with_copy;
    @(negedge clk);
    pos_load = 1'b0; copy_done = 1'b0;
    #1;
  endtask

  task automatic sector();
    @(negedge clk);
    sector_done = 1'b1;
    @(negedge clk);
    sector_done = 1'b0;
    #1;
  endtask

  task automatic copy();
    @(negedge clk);
    copy_done = 1'b1;
    @(negedge clk);
    copy_done = 1'b0;
    #1;
  endtask

  task automatic read_hdr(input logic [7:0] m, input logic [7:0] s, input logic [7:0] f, input string tag);
    rd(4'h0, m, {tag, " min"});
    rd(4'h1, s, {tag, " sec"});
    rd(4'h2, f, {tag, " frm"});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 irq_n", {15'b0, irq_n}, 16'h1);
    check("R1 msf_inc", {15'b0, msf_inc}, 16'h0);
    check("R1 count", {4'b0, xfer_count}, 16'h0);
    check("R1 addr", xfer_addr, 16'h0);
    read_hdr(8'h00, 8'h00, 8'h00, "R1 header");
    rd(4'hD, 8'h00, "R1 enable");

    // R2 position load
    load_pos(8'h12, 8'h34, 8'h56, 1'b0);
    read_hdr(8'h12, 8'h34, 8'h56, "R2 header");

    // R3 status values
    rd(4'h3, 8'h80, "R3 stat0");
    rd(4'h4, 8'h00, "R3 stat1");
    rd(4'h5, 8'h00, "R3 stat2");
    rd(4'h6, 8'h00, "R3 stat3");

    // R4 pointer and read-only writes
    rd(4'h7, 8'h04, "R4 ptr lo");
    rd(4'h8, 8'h00, "R4 ptr hi");
    wr(4'h7, 8'h55);
    wr(4'h0, 8'h99);
    wr(4'h3, 8'h11);
    rd(4'h7, 8'h04, "R4 ptr lo after write");
    rd(4'h0, 8'h12, "R4 header after write");
    rd(4'h3, 8'h80, "R4 stat0 after write");

    // R5 count and address
    wr(4'h9, 8'hFF);
    wr(4'hA, 8'h07);
    check("R5 xfer_count", {4'b0, xfer_count}, 16'h07FF);
    rd(4'hA, 8'h07, "R5 count hi");
    wr(4'hA, 8'hFF);
    rd(4'hA, 8'h0F, "R5 count hi masked");
    wr(4'hA, 8'h07);
    wr(4'hB, 8'h34);
    wr(4'hC, 8'h12);
    check("R5 xfer_addr", xfer_addr, 16'h1234);
    rd(4'hB, 8'h34, "R5 addr lo");
    rd(4'hC, 8'h12, "R5 addr hi");
    wr(4'hB, 8'h00);
    wr(4'hC, 8'h00);
    check("R5 xfer_addr zero", xfer_addr, 16'h0000);

    // R8 sector while disabled is dropped
    sector();
    check("R8 disabled sector", {15'b0, irq_n}, 16'h1);
    wr(4'hD, 8'h01);
    check("R8 enable after dropped", {15'b0, irq_n}, 16'h1);

    // R6 raise and hold
    sector();
    check("R6 irq low", {15'b0, irq_n}, 16'h0);
    repeat (3) @(negedge clk);
    #1;
    check("R6 irq held", {15'b0, irq_n}, 16'h0);

    // R7 status 3 read clears, reraise
    rd(4'h6, 8'h00, "R7 stat3 read");
    #1;
    check("R7 irq cleared", {15'b0, irq_n}, 16'h1);
    sector();
    check("R7 irq again", {15'b0, irq_n}, 16'h0);
    rd(4'h6, 8'h00, "R7 stat3 read 2");
    #1;
    check("R7 irq cleared 2", {15'b0, irq_n}, 16'h1);

    // R8 disable releases and discards
    sector();
    check("R8 irq low", {15'b0, irq_n}, 16'h0);
    wr(4'hD, 8'h00);
    check("R8 disable releases", {15'b0, irq_n}, 16'h1);
    wr(4'hD, 8'h01);
    check("R8 pending discarded", {15'b0, irq_n}, 16'h1);

    // R9 one-cycle pulse and advance
    load_pos(8'h00, 8'h02, 8'h10, 1'b0);
    check("R9 idle inc", {15'b0, msf_inc}, 16'h0);
    copy();
    check("R9 inc pulse", {15'b0, msf_inc}, 16'h1);
    @(negedge clk); #1;
    check("R9 inc ends", {15'b0, msf_inc}, 16'h0);
    read_hdr(8'h00, 8'h02, 8'h11, "R9 advance");

    // R10 BCD carries
    load_pos(8'h00, 8'h00, 8'h09, 1'b0);
    copy();
    read_hdr(8'h00, 8'h00, 8'h10, "R10 digit carry");
    load_pos(8'h00, 8'h02, 8'h74, 1'b0);
    copy();
    read_hdr(8'h00, 8'h03, 8'h00, "R10 frame wrap");
    load_pos(8'h00, 8'h59, 8'h74, 1'b0);
    copy();
    read_hdr(8'h01, 8'h00, 8'h00, "R10 second wrap");
    load_pos(8'h99, 8'h59, 8'h74, 1'b0);
    copy();
    read_hdr(8'h00, 8'h00, 8'h00, "R10 minute wrap");

    // R11 load beats advance
    load_pos(8'h05, 8'h06, 8'h07, 1'b1);
    check("R11 inc still pulses", {15'b0, msf_inc}, 16'h1);
    read_hdr(8'h05, 8'h06, 8'h07, "R11 load wins");

    repeat (3) @(negedge clk);
    if (exp_val.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_val.size());
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule